// File: doc/BRIEF.md
# Autocorrelation Lag Feed Generator

This block prepares the two input streams of a cross-correlator lag array so that the array computes an autocorrelation. Each clock it may accept one word holding eight 2-bit samples; at 128 MHz that is 1024 Msample/s. It returns two words: the word just accepted, and the word accepted 32 words earlier. Because each word holds 8 samples, the second stream lags the first by 256 samples, which is half of a 512-lag correlator span. Both streams come from the same signal, so a correlator fed with them sees lags that are symmetric around the delay, and it yields an autocorrelation spectrum.

The delay is counted in accepted words only. Idle cycles, where the input valid is low, do not move the line. Dropping the enable discards the fill history. After reset, or after the enable returns, the output valid stays low until 32 new words have entered the line. Samples are not altered in any way.

Top module: `lagfeed_gen`

## Requirements
- R1: While reset is applied, and until the first accepted word after reset, `pair_vld_o` is 0 and both output words are 0.
- R2: When `pair_vld_o` is 1, `now_word_o` equals the `in_word_i` accepted in the previous clock. A word is accepted when `en_i` and `in_vld_i` are both 1. The latency is one clock.
- R3: When `pair_vld_o` is 1, `late_word_o` equals the word accepted 32 accepted words before the one on `now_word_o`. That is 256 samples with the default parameters.
- R4: The first 32 words accepted after reset, or after `en_i` rises, produce `pair_vld_o` = 0. Every accepted word after them produces `pair_vld_o` = 1 in the next clock.
- R5: While `en_i` is 0, input words are ignored and `pair_vld_o` is 0 in the next clock. The fill count restarts, so R4 applies again once `en_i` returns to 1.
- R6: A cycle with `in_vld_i` = 0 does not advance the delay line, and `pair_vld_o` is 0 in the next clock. Gaps of any pattern leave the 32-word alignment between the two streams unchanged.
- R7: Sample k of a word sits in bits [2k+1:2k], with k = 0 the oldest sample. Bit 1 of each sample is the sign and bit 0 is the magnitude. Both output streams carry every bit unchanged and in the same positions.
- R8: After a cycle in which no word is accepted, `now_word_o` and `late_word_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised internally |
| en_i | input | 1 | Enable; when low, input is ignored and the fill history is cleared |
| in_vld_i | input | 1 | Input word qualifier |
| in_word_i | input | 16 | Eight 2-bit samples, oldest in bits [1:0] |
| pair_vld_o | output | 1 | Both output words are valid this cycle |
| now_word_o | output | 16 | Immediate copy of the accepted word |
| late_word_o | output | 16 | Copy of the word accepted 32 words earlier |

## Verification
The assertions assume that `en_i` stays low until the internal reset release has passed. The first word is therefore accepted only after the synchroniser has let go. The stimulus keeps the enable low for several clocks after reset. The properties place no limit on the contents of the input words, on the gap pattern or on the enable pattern. For that reason the stimulus mixes continuous words, periodic idle cycles, enable drops made while words are still offered, and a marker word that exercises every sample field position.

// File: rtl/lagfeed_pkg.sv
package lagfeed_pkg;
  localparam int LANES_DEF = 8;
  localparam int SMP_W_DEF = 2;
  localparam int LAGS_DEF  = 512;
endpackage

// File: rtl/lagfeed_rst_sync.sv
module lagfeed_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/lagfeed_fill_track.sv
module lagfeed_fill_track #(
  parameter int DEPTH = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic push,
  output logic full
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!en)                          cnt_d = '0;
    else if (push && cnt_q != FULL_CNT) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign full = (cnt_q == FULL_CNT);
endmodule

// File: rtl/lagfeed_delay_line.sv
module lagfeed_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] tail
);
  logic [W-1:0] stg_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] src;
    logic [W-1:0] stg_d;

    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stg_q[i-1];
    end

    always_comb begin
      stg_d = stg_q[i];
      if (shift) stg_d = src;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= '0;
      else        stg_q[i] <= stg_d;
    end
  end

  assign tail = stg_q[DEPTH-1];
endmodule

// File: rtl/lagfeed_gen.sv
module lagfeed_gen
  import lagfeed_pkg::*;
#(
  parameter int LANES = LANES_DEF,
  parameter int SMP_W = SMP_W_DEF,
  parameter int LAGS  = LAGS_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     in_vld_i,
  input  logic [LANES*SMP_W-1:0]   in_word_i,
  output logic                     pair_vld_o,
  output logic [LANES*SMP_W-1:0]   now_word_o,
  output logic [LANES*SMP_W-1:0]   late_word_o
);
  localparam int WORD_W   = LANES * SMP_W;
  localparam int HALF_SMP = LAGS / 2;
  localparam int DEPTH    = HALF_SMP / LANES;

  logic              rst_int_n;
  logic              push;
  logic              full;
  logic [WORD_W-1:0] tail;

  logic              vld_q, vld_d;
  logic [WORD_W-1:0] now_q, now_d;
  logic [WORD_W-1:0] late_q, late_d;

  lagfeed_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  assign push = en_i & in_vld_i;

  lagfeed_fill_track #(.DEPTH(DEPTH)) u_fill (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (en_i),
    .push  (push),
    .full  (full)
  );

  lagfeed_delay_line #(.W(WORD_W), .DEPTH(DEPTH)) u_line (
    .clk   (clk),
    .rst_n (rst_int_n),
    .shift (push),
    .din   (in_word_i),
    .tail  (tail)
  );

  always_comb begin
    vld_d  = push & full;
    now_d  = now_q;
    late_d = late_q;
    if (push) begin
      now_d  = in_word_i;
      late_d = tail;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      now_q  <= '0;
      late_q <= '0;
    end else begin
      vld_q  <= vld_d;
      now_q  <= now_d;
      late_q <= late_d;
    end
  end

  assign pair_vld_o  = vld_q;
  assign now_word_o  = now_q;
  assign late_word_o = late_q;
endmodule

// File: rtl/lagfeed_gen_chk.sv
module lagfeed_gen_chk #(
  parameter int LANES = 8,
  parameter int SMP_W = 2,
  parameter int LAGS  = 512
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   en_i,
  input logic                   in_vld_i,
  input logic [LANES*SMP_W-1:0] in_word_i,
  input logic                   pair_vld_o,
  input logic [LANES*SMP_W-1:0] now_word_o,
  input logic [LANES*SMP_W-1:0] late_word_o
);
  localparam int DEPTH = (LAGS / 2) / LANES;
  localparam int CW    = $clog2(DEPTH + 1);

  logic [CW-1:0] seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 seen_q <= '0;
    else if (!en_i)                             seen_q <= '0;
    else if (in_vld_i && seen_q != CW'(DEPTH))  seen_q <= seen_q + 1'b1;
  end

  assert_now_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pair_vld_o |-> now_word_o == $past(in_word_i));

  assert_no_early_vld_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && in_vld_i && seen_q != CW'(DEPTH)) |=> !pair_vld_o);

  assert_off_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !pair_vld_o);

  assert_gap_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld_i |=> !pair_vld_o);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(en_i && in_vld_i) |=> ($stable(now_word_o) && $stable(late_word_o)));
endmodule

bind lagfeed_gen lagfeed_gen_chk #(.LANES(LANES), .SMP_W(SMP_W), .LAGS(LAGS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .en_i        (en_i),
  .in_vld_i    (in_vld_i),
  .in_word_i   (in_word_i),
  .pair_vld_o  (pair_vld_o),
  .now_word_o  (now_word_o),
  .late_word_o (late_word_o)
);

// File: tb/sim_lagfeed_gen.sv
`timescale 1ns/1ps
module sim_lagfeed_gen;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        in_vld_i = 1'b0;
  logic [15:0] in_word_i = '0;
  logic        pair_vld_o;
  logic [15:0] now_word_o, late_word_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 0;
  bit chk_on = 0;
  string tag = "R4";

  lagfeed_gen u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .in_vld_i(in_vld_i),
    .in_word_i(in_word_i), .pair_vld_o(pair_vld_o),
    .now_word_o(now_word_o), .late_word_o(late_word_o)
  );

  always #4 clk = ~clk;

  // reference model: history of words accepted since last enable
  logic [15:0] hist[$];
  logic        exp_vld = 0;
  logic [15:0] exp_now = '0;
  logic [15:0] exp_late = '0;
  logic        acc_q = 0;
  logic [15:0] prev_late = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist.delete();
      exp_vld <= 0; exp_now <= '0; exp_late <= '0; acc_q <= 0;
    end else if (!en_i) begin
      hist.delete();
      exp_vld <= 0; acc_q <= 0;
    end else if (in_vld_i) begin
      exp_vld <= (hist.size() >= DEPTH);
      if (hist.size() >= DEPTH) exp_late <= hist[hist.size()-DEPTH];
      exp_now <= in_word_i;
      hist.push_back(in_word_i);
      acc_q <= 1;
    end else begin
      exp_vld <= 0; acc_q <= 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(pair_vld_o == exp_vld, tag, 16'(pair_vld_o), 16'(exp_vld));
      chk(now_word_o == exp_now, "R2", now_word_o, exp_now);
      if (exp_vld) chk(late_word_o == exp_late, "R3", late_word_o, exp_late);
      if (!acc_q)  chk(late_word_o == prev_late, "R8", late_word_o, prev_late);
      prev_late = late_word_o;
    end
  end

  function automatic logic [15:0] mk(input int k);
    return 16'((k * 40503 + 4660) & 16'hFFFF);
  endfunction

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    en_i = 1; in_vld_i = 1; in_word_i = w;
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld_i = 0; in_word_i = 16'hDEAD;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int vld_cnt;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(pair_vld_o == 0, "R1", 16'(pair_vld_o), 16'h0);
    chk(now_word_o == 0, "R1", now_word_o, 16'h0);
    chk(late_word_o == 0, "R1", late_word_o, 16'h0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk(pair_vld_o == 0 && now_word_o == 0 && late_word_o == 0, "R1", now_word_o, 16'h0);
    chk_on = 1;

    // R4: continuous fill and stream
    tag = "R4";
    for (int k = 0; k < 90; k++) push(mk(k));

    // R6: idle gaps, alignment counted in accepted words
    tag = "R6";
    for (int k = 0; k < 90; k++) begin
      if (k % 3 == 2) idle(); else push(mk(k + 200));
    end
    idle(); idle();

    // R5: enable dropped while words are offered
    tag = "R5";
    @(negedge clk); en_i = 0; in_vld_i = 1; in_word_i = 16'hBEEF;
    repeat (3) @(negedge clk);
    chk(pair_vld_o == 0, "R5", 16'(pair_vld_o), 16'h0);
    chk(now_word_o == exp_now, "R5", now_word_o, exp_now);
    vld_cnt = 0;
    for (int k = 0; k < DEPTH; k++) begin
      push(mk(k + 500));
      #1 if (pair_vld_o) vld_cnt++;
    end
    @(negedge clk); in_vld_i = 0;
    #1 if (pair_vld_o) vld_cnt++;
    chk(vld_cnt == 0, "R5", 16'(vld_cnt), 16'h0);
    for (int k = 0; k < 10; k++) push(mk(k + 600));

    // R7: marker word, field positions preserved in both streams
    tag = "R7";
    push(16'hE4E4);
    @(negedge clk); in_vld_i = 0;
    #1 chk(now_word_o == 16'hE4E4, "R7", now_word_o, 16'hE4E4);
    for (int k = 0; k < DEPTH; k++) push(mk(k + 700));
    @(negedge clk); in_vld_i = 0;
    #1;
    chk(late_word_o == 16'hE4E4, "R7", late_word_o, 16'hE4E4);
    chk(late_word_o[1:0] == 2'b00 && late_word_o[15:14] == 2'b11, "R7",
        late_word_o, 16'hE4E4);
    chk(late_word_o[3:2] == 2'b01 && late_word_o[5:4] == 2'b10, "R7",
        late_word_o, 16'hE4E4);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule